// File: doc/BRIEF.md
# Dual-Block Broadcast Configuration Store

This block keeps the configuration words for an 8 by 8 array of compute cells. It delivers them to the array as one wide context bus. The storage is split into two halves. The row half has one context set per array row. The column half has one context set per array column. Each set holds sixteen 32-bit words, so the whole store is 256 words.

An execute command names a depth index and a broadcast mode. In row mode, word d of each row set goes to every cell of the matching row. In column mode, word d of each column set goes to every cell of the matching column. The eight words are read in parallel and registered onto a 256-bit bus one cycle after the command. A valid strobe and a mode bit travel with them.

A loader fills the store through a write port that uses a valid/ready handshake. The block never applies back-pressure: `wr_ready` is high whenever the block is out of reset, so every offered word is taken in the cycle it is presented. Each taken word is either written or refused. The half that the array is currently running from is marked busy, and writes aimed at it are refused and reported with an error pulse. The other half may be reloaded while execution continues. The context bus output has no ready: the array consumes every strobe.

Top module: `ctxm_broadcast_mem`

## Requirements
- R1: A write address is 8 bits. Bit 7 selects the half (0 = row half, 1 = column half), bits 6:4 select the set (row or column number), and bits 3:0 select the depth. An accepted word is read back by a later execute from exactly that half, set and depth.
- R2: An execute with mode m and depth index d places, for every k in 0..7, word d of set k of half m on bus bits [32k+31:32k].
- R3: `ctx_valid` is high in exactly the cycle after an execute command and low otherwise. `ctx_mode` then equals the command's mode (0 = row, 1 = column).
- R4: After reset neither half is busy. An execute in mode m makes half m busy and the other half idle. A `run_stop` pulse without a concurrent execute makes both halves idle; when both arrive together, the execute wins.
- R5: A write is refused if its target half is busy or is the half named by an execute in the same cycle. A refused write leaves the stored contents unchanged, and `wr_err` is high for one cycle, in the cycle after the write.
- R6: A write to an idle half that is not being executed completes in one cycle. An execute in the very next cycle already reads the new word, and `wr_err` stays low.
- R7: While reset is asserted, `ctx_valid` and `wr_err` are low and every stored word is cleared to zero. `wr_ready` is high whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Loader offers a word |
| wr_ready | output | 1 | Block accepts the offer (high when out of reset) |
| wr_addr | input | 8 | {half, set[2:0], depth[3:0]} |
| wr_data | input | 32 | Configuration word |
| wr_err | output | 1 | Previous-cycle write was refused |
| ex_valid | input | 1 | Execute command |
| ex_mode | input | 1 | 0 = row broadcast, 1 = column broadcast |
| ex_idx | input | 4 | Depth index to execute |
| run_stop | input | 1 | Release the busy half |
| ctx_valid | output | 1 | Context bus carries fresh words |
| ctx_mode | output | 1 | Broadcast mode of the bus contents |
| ctx_bus | output | 256 | Eight 32-bit words, word k for row/column k |

## Verification
The busy marking never appears at the ports directly, so a wrong busy state shows up through the writes. A write refused in error raises `wr_err` one cycle later. A write wrongly let through into the running half shows up at the next execute of that half, as a bus word that differs from the one the loader stored. Lane-ordering or mode-selection faults corrupt the bus in the first cycle after an execute. A stale or dropped write is exposed at the first execute that reads that depth. The bench predicts every output on every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;
  // Broadcast direction of a context; also selects the storage half.
  typedef enum logic {
    BC_ROW = 1'b0,
    BC_COL = 1'b1
  } bc_mode_e;

  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/ctxm_set_bank.sv
// One context set: DEPTH words with one write port and one combinational read port.
module ctxm_set_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int DEP_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DEP_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [DEP_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (we) begin
      words_q[waddr] <= wdata;
    end
  end

  assign rdata = words_q[raddr];
endmodule

// File: rtl/ctxm_half.sv
// One storage half: LANES sets read at a common depth, written one word at a time.
module ctxm_half #(
  parameter int WORD_W = 32,
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  localparam int DEP_W = $clog2(DEPTH),
  localparam int SET_W = $clog2(LANES),
  localparam int BUS_W = WORD_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [DEP_W-1:0]  wr_depth,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DEP_W-1:0]  rd_depth,
  output logic [BUS_W-1:0]  rd_bus
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_we;
    assign lane_we = wr_en && (wr_set == SET_W'(k));

    ctxm_set_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we),
      .waddr (wr_depth),
      .wdata (wr_data),
      .raddr (rd_depth),
      .rdata (rd_bus[k*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/ctxm_guard.sv
// Tracks which half the array runs from and decides whether a write may proceed.
module ctxm_guard
  import ctxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_half,
  input  logic       ex_valid,
  input  bc_mode_e   ex_mode,
  input  logic       run_stop,
  output logic       wr_commit,
  output logic [1:0] half_busy,
  output logic       wr_err
);
  logic     act_q;
  bc_mode_e act_mode_q;
  logic     clash;
  logic     blocked;

  assign half_busy[0] = act_q && (act_mode_q == BC_ROW);
  assign half_busy[1] = act_q && (act_mode_q == BC_COL);

  assign clash     = ex_valid && (logic'(ex_mode) == wr_half);
  assign blocked   = half_busy[wr_half] || clash;
  assign wr_commit = wr_valid && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      act_mode_q <= BC_ROW;
      wr_err     <= 1'b0;
    end else begin
      wr_err <= wr_valid && blocked;
      if (ex_valid) begin
        act_q      <= 1'b1;
        act_mode_q <= ex_mode;
      end else if (run_stop) begin
        act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctxm_bus_stage.sv
// Selects the half named by the execute and registers the wide context bus.
module ctxm_bus_stage
  import ctxm_pkg::*;
#(
  parameter int BUS_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  bc_mode_e         ex_mode,
  input  logic [BUS_W-1:0] row_bus,
  input  logic [BUS_W-1:0] col_bus,
  output logic             ctx_valid,
  output logic             ctx_mode,
  output logic [BUS_W-1:0] ctx_bus
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_valid <= 1'b0;
      ctx_mode  <= 1'b0;
      ctx_bus   <= '0;
    end else begin
      ctx_valid <= ex_valid;
      if (ex_valid) begin
        ctx_mode <= logic'(ex_mode);
        ctx_bus  <= (ex_mode == BC_COL) ? col_bus : row_bus;
      end
    end
  end
endmodule

// File: rtl/ctxm_broadcast_mem.sv
module ctxm_broadcast_mem
  import ctxm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LANES   = 8,
  parameter int DEPTH   = 16,
  localparam int DEP_W  = $clog2(DEPTH),
  localparam int SET_W  = $clog2(LANES),
  localparam int ADDR_W = 1 + SET_W + DEP_W,
  localparam int BUS_W  = WORD_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              ex_valid,
  input  logic              ex_mode,
  input  logic [DEP_W-1:0]  ex_idx,
  input  logic              run_stop,
  output logic              ctx_valid,
  output logic              ctx_mode,
  output logic [BUS_W-1:0]  ctx_bus
);
  logic             wr_half;
  logic [SET_W-1:0] wr_set;
  logic [DEP_W-1:0] wr_depth;
  logic             wr_commit;
  logic [1:0]       blk_busy;
  bc_mode_e         ex_mode_e;
  logic [BUS_W-1:0] half_bus [NUM_HALVES];

  assign wr_half   = wr_addr[ADDR_W-1];
  assign wr_set    = wr_addr[DEP_W +: SET_W];
  assign wr_depth  = wr_addr[DEP_W-1:0];
  assign ex_mode_e = bc_mode_e'(ex_mode);
  assign wr_ready  = rst_n;

  ctxm_guard guard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_half   (wr_half),
    .ex_valid  (ex_valid),
    .ex_mode   (ex_mode_e),
    .run_stop  (run_stop),
    .wr_commit (wr_commit),
    .half_busy (blk_busy),
    .wr_err    (wr_err)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic half_we;
    assign half_we = wr_commit && (wr_half == 1'(h));

    ctxm_half #(.WORD_W(WORD_W), .LANES(LANES), .DEPTH(DEPTH)) half_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (half_we),
      .wr_set   (wr_set),
      .wr_depth (wr_depth),
      .wr_data  (wr_data),
      .rd_depth (ex_idx),
      .rd_bus   (half_bus[h])
    );
  end

  ctxm_bus_stage #(.BUS_W(BUS_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_mode   (ex_mode_e),
    .row_bus   (half_bus[0]),
    .col_bus   (half_bus[1]),
    .ctx_valid (ctx_valid),
    .ctx_mode  (ctx_mode),
    .ctx_bus   (ctx_bus)
  );
endmodule

// File: rtl/ctxm_checker.sv
module ctxm_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_err,
  input logic              ex_valid,
  input logic              ex_mode,
  input logic              ctx_valid,
  input logic              ctx_mode,
  input logic [1:0]        busy
);
  p_exec_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> ctx_valid);
  p_idle_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> !ctx_valid);
  p_mode_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> (ctx_mode == $past(ex_mode)));
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid));
  p_clash_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ex_valid && (wr_addr[ADDR_W-1] == ex_mode)) |=> wr_err);
  p_busy_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy[wr_addr[ADDR_W-1]]) |=> wr_err);
  p_one_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
  p_busy_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> busy[$past(ex_mode)]);
endmodule

bind ctxm_broadcast_mem ctxm_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_err    (wr_err),
  .ex_valid  (ex_valid),
  .ex_mode   (ex_mode),
  .ctx_valid (ctx_valid),
  .ctx_mode  (ctx_mode),
  .busy      (blk_busy)
);

// File: tb/ctxm_broadcast_mem_tb.sv
`timescale 1ns/1ps
module ctxm_broadcast_mem_tb_top;
  localparam real CLK_HALF = 2.0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [7:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         wr_err;
  logic         ex_valid = 1'b0;
  logic         ex_mode = 1'b0;
  logic [3:0]   ex_idx = '0;
  logic         run_stop = 1'b0;
  logic         ctx_valid;
  logic         ctx_mode;
  logic [255:0] ctx_bus;

  always #(CLK_HALF) clk = ~clk;

  ctxm_broadcast_mem dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_err(wr_err),
    .ex_valid(ex_valid), .ex_mode(ex_mode), .ex_idx(ex_idx),
    .run_stop(run_stop),
    .ctx_valid(ctx_valid), .ctx_mode(ctx_mode), .ctx_bus(ctx_bus)
  );

  // Behavioural reference state
  logic [31:0]  ref_mem [2][8][16];
  int           active = -1;        // -1: no half busy
  logic         exp_valid = 1'b0;
  logic         exp_mode = 1'b0;
  logic [255:0] exp_bus = '0;
  logic         exp_err = 1'b0;
  string        tag_err = "R7";
  string        tag_bus = "R2";
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare outputs (mid-cycle), then drive the next inputs and predict their effect.
  task automatic cyc(input logic wv, input logic [7:0] wa, input logic [31:0] wd,
                     input logic ev, input logic em, input logic [3:0] ei,
                     input logic stop, input string btag);
    int  blk;
    bit  blocked;
    @(negedge clk);
    chk("R7", "wr_ready", 256'(wr_ready), 256'(1'b1));
    chk("R3", "ctx_valid", 256'(ctx_valid), 256'(exp_valid));
    chk(tag_err, "wr_err", 256'(wr_err), 256'(exp_err));
    if (exp_valid) begin
      chk("R3", "ctx_mode", 256'(ctx_mode), 256'(exp_mode));
      chk(tag_bus, "ctx_bus", ctx_bus, exp_bus);
    end
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    ex_valid = ev; ex_mode = em; ex_idx = ei; run_stop = stop;
    blk     = int'(wa[7]);
    blocked = (active == blk) || (ev && (int'(em) == blk));
    exp_err = wv && blocked;
    if (wv && blocked) tag_err = (active == blk) ? "R4" : "R5";
    else if (wv)       tag_err = "R6";
    else               tag_err = "R5";
    exp_valid = ev;
    if (ev) begin
      exp_mode = em;
      tag_bus  = btag;
      for (int k = 0; k < 8; k++) exp_bus[32*k +: 32] = ref_mem[int'(em)][k][ei];
    end
    if (wv && !blocked) ref_mem[blk][wa[6:4]][wa[3:0]] = wd;
    if (ev)        active = int'(em);
    else if (stop) active = -1;
  endtask

  function automatic logic [31:0] pat(input int b, input int s, input int d);
    return {8'(b + 8'h61), 8'(s * 17 + 3), 8'(d * 5 + 1), 8'h5A};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int d = 0; d < 16; d++) ref_mem[b][s][d] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7: reset state of outputs
    chk("R7", "ctx_valid in reset", 256'(ctx_valid), 256'(1'b0));
    chk("R7", "wr_err in reset", 256'(wr_err), 256'(1'b0));
    rst_n = 1'b1;

    // R7: cleared storage after reset, both halves
    cyc(0, 0, 0, 1, 0, 4'd0, 0, "R7");
    cyc(0, 0, 0, 1, 1, 4'd15, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, "R2");   // release busy half (R4)

    // R1: fill every word of both halves at idle
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int d = 0; d < 16; d++)
          cyc(1, {1'(b), 3'(s), 4'(d)}, pat(b, s, d), 0, 0, 0, 0, "R1");

    // R1/R2: read back every depth in both modes
    for (int d = 0; d < 16; d++) begin
      cyc(0, 0, 0, 1, 0, 4'(d), 0, "R1");
      cyc(0, 0, 0, 1, 1, 4'(d), 0, "R2");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, "R2");

    // R4: column half busy after last execute; write to it refused, row write allowed
    cyc(1, {1'b1, 3'd2, 4'd7}, 32'hDEAD_0001, 0, 0, 0, 0, "R4");
    cyc(1, {1'b0, 3'd5, 4'd9}, 32'h1234_5678, 0, 0, 0, 0, "R6");
    // R6: row word visible at the very next execute
    cyc(0, 0, 0, 1, 0, 4'd9, 0, "R6");
    // row half now busy: R4 refuse row, allow column write
    cyc(1, {1'b0, 3'd1, 4'd9}, 32'hBAD0_BAD0, 0, 0, 0, 0, "R4");
    cyc(1, {1'b1, 3'd2, 4'd7}, 32'hC0DE_0007, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 1, 4'd7, 0, "R6");
    cyc(0, 0, 0, 1, 0, 4'd9, 0, "R5");  // refused row write left data intact

    // R5: write clashing with a same-cycle execute of the same half
    cyc(0, 0, 0, 0, 0, 0, 1, "R4");
    cyc(1, {1'b1, 3'd3, 4'd3}, 32'hFFFF_0000, 1, 1, 4'd3, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 1, 1, 4'd3, 0, "R5");  // contents unchanged
    // R4: run_stop together with execute, execute wins
    cyc(0, 0, 0, 1, 0, 4'd2, 1, "R4");
    cyc(1, {1'b0, 3'd0, 4'd2}, 32'h0BAD_0BAD, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, "R4");
    cyc(1, {1'b0, 3'd0, 4'd2}, 32'h600D_600D, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 4'd2, 0, "R6");

    // Mixed traffic
    for (int n = 0; n < 3000; n++)
      cyc(1'($urandom), 8'($urandom), $urandom, ($urandom % 3) == 0,
          1'($urandom), 4'($urandom), ($urandom % 8) == 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule